// File: doc/BRIEF.md
# Nibble-bus real-time-clock register port

This block is the host-facing front end of a real-time clock. A host drives a 4-bit data nibble together with two chip selects and three level-sensitive strobes: one that loads the register address, one that stores data into the addressed register, and one that puts the addressed register on the output nibble. Every host input crosses into the block's clock domain through a two-flop synchronizer. Only the synchronized levels are decoded, so a strobe acts for as long as it is held high and no edge is needed.

Thirteen time registers sit behind a 16-entry address space. Each register keeps only the bits that its field can legally hold. The hour-tens register also applies a side effect: selecting 24-hour mode clears the PM flag. The address after the last time register triggers a one-cycle clear pulse for the seconds prescaler in the timekeeping logic. The two addresses above it accept no data. Every accepted store is also shown on a register-file port, so the timekeeping counters can follow the loaded values.

Top module: `nib_rtc_port`

## Requirements
- R1: After reset, the output nibble is 0xF and the address latch holds 15. A selected read with no address loaded therefore returns 0.
- R2: The block acts on the bus only while both chip selects are high. Otherwise the strobes have no effect: the address latch and the registers keep their values and the output nibble is 0xF.
- R3: While the block is selected and the address strobe is high, the synchronized data nibble is copied into the address latch on every clock.
- R4: While the block is selected and the write strobe is high, the nibble is stored into the addressed register. Registers 0, 2, 4, 7, 8, 9, 11 and 12 keep all 4 bits.
- R5: Registers 1 (seconds tens), 3 (minutes tens) and 6 (weekday) keep only bits 2:0. Bit 3 is stored as 0.
- R6: Register 10 (month tens) keeps only bit 0. Bits 3:1 are stored as 0.
- R7: In register 5 (hour tens), bit 3 selects 24-hour mode and bit 2 is the PM flag. If a stored nibble has bit 3 set, bit 2 is stored as 0. If bit 3 is clear, the nibble is stored unchanged.
- R8: While the block is selected and the read strobe is high, the output nibble shows register 0–12 at the latched address, and 0 for addresses 13, 14 and 15. In all other cases it shows 0xF.
- R9: Holding a write to address 13 gives exactly one cycle of the prescaler clear output and changes no register.
- R10: Writes to addresses 14 and 15 change no register and raise neither the register-file write enable nor the clear output.
- R11: While a write to registers 0–12 is accepted, the register-file port shows the write enable high, the index equal to the address, and the data after masking.
- R12: A host input change reaches the outputs only after two clock edges. The output is unchanged one edge after the read strobe rises and correct after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_a_i | input | 1 | Chip select A, active high |
| sel_b_i | input | 1 | Chip select B, active high |
| addr_stb_i | input | 1 | Address-load strobe, level sensitive |
| wr_stb_i | input | 1 | Write strobe, level sensitive |
| rd_stb_i | input | 1 | Read strobe, level sensitive |
| din_i | input | 4 | Host data nibble |
| dout_o | output | 4 | Read data nibble |
| tk_we_o | output | 1 | Register-file write enable toward timekeeping |
| tk_idx_o | output | 4 | Register-file index |
| tk_wdata_o | output | 4 | Masked register-file write data |
| presc_clr_o | output | 1 | One-cycle seconds-prescaler clear |

## Verification
The assertions assume that the host keeps the data nibble steady while a strobe is held high, and that it changes the nibble only after the strobe has been low for the synchronizer depth. Otherwise a level strobe could load a nibble that is changing. The bench follows this rule: every address, write and read phase holds its data for four clocks, then rests three clocks before anything else changes. Deselection is applied only between phases, never in the middle of one.

// File: rtl/nib_rtc_pkg.sv
package nib_rtc_pkg;
  localparam int NIB_W     = 4;
  localparam int REG_CNT   = 13;
  localparam int ADDR_W    = 4;
  localparam logic [ADDR_W-1:0] IDX_SEC_T  = 4'd1;
  localparam logic [ADDR_W-1:0] IDX_MIN_T  = 4'd3;
  localparam logic [ADDR_W-1:0] IDX_HOUR_T = 4'd5;
  localparam logic [ADDR_W-1:0] IDX_WDAY   = 4'd6;
  localparam logic [ADDR_W-1:0] IDX_MON_T  = 4'd10;
  localparam logic [ADDR_W-1:0] ADDR_PCLR  = 4'd13;
  localparam int HOUR_PM_BIT  = 2;
  localparam int HOUR_24H_BIT = 3;

  function automatic logic [NIB_W-1:0] wr_mask(input logic [ADDR_W-1:0] idx,
                                               input logic [NIB_W-1:0] d);
    logic [NIB_W-1:0] m;
    m = d;
    if (idx == IDX_SEC_T || idx == IDX_MIN_T || idx == IDX_WDAY) begin
      m[NIB_W-1] = 1'b0;
    end else if (idx == IDX_MON_T) begin
      m[NIB_W-1:1] = '0;
    end else if (idx == IDX_HOUR_T && d[HOUR_24H_BIT]) begin
      m[HOUR_PM_BIT] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile
  import nib_rtc_pkg::*;
#(
  parameter int CNT = REG_CNT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    idx_i,
  input  logic [NIB_W-1:0]     wdata_i,
  output logic [CNT*NIB_W-1:0] q_flat_o
);
  generate
    for (genvar i = 0; i < CNT; i++) begin : g_reg
      logic [NIB_W-1:0] r_q, r_d;
      logic             r_en;
      always_comb begin
        r_en = we_i && (idx_i == ADDR_W'(i));
        r_d  = r_q;
        if (r_en) r_d = wdata_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
      end
      assign q_flat_o[i*NIB_W +: NIB_W] = r_q;
    end
  endgenerate
endmodule

// File: rtl/nib_rdmux.sv
module nib_rdmux
  import nib_rtc_pkg::*;
#(
  parameter int CNT = REG_CNT
) (
  input  logic                 en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [CNT*NIB_W-1:0] q_flat_i,
  output logic [NIB_W-1:0]     dout_o
);
  logic [NIB_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < CNT; i++) begin
      if (addr_i == ADDR_W'(i)) pick = q_flat_i[i*NIB_W +: NIB_W];
    end
    dout_o = en_i ? pick : '1;
  end
endmodule

// File: rtl/nib_rtc_port.sv
module nib_rtc_port
  import nib_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_a_i,
  input  logic             sel_b_i,
  input  logic             addr_stb_i,
  input  logic             wr_stb_i,
  input  logic             rd_stb_i,
  input  logic [NIB_W-1:0] din_i,
  output logic [NIB_W-1:0] dout_o,
  output logic             tk_we_o,
  output logic [ADDR_W-1:0] tk_idx_o,
  output logic [NIB_W-1:0] tk_wdata_o,
  output logic             presc_clr_o
);
  localparam int IN_W = 5 + NIB_W;

  logic             rst_n_s;
  logic [IN_W-1:0]  in_s;
  logic             sel_a_s, sel_b_s, adr_s, wr_s, rd_s;
  logic [NIB_W-1:0] din_s;
  logic             sel_ok, wr_ok, addr_en, pclr_hit;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic             pclr_q, pclr_d;
  logic [REG_CNT*NIB_W-1:0] regs_flat;

  nib_sync #(.W(1), .STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_s)
  );

  nib_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) i_in_sync (
    .clk(clk), .rst_n(rst_n_s),
    .d_i({sel_a_i, sel_b_i, addr_stb_i, wr_stb_i, rd_stb_i, din_i}),
    .q_o(in_s)
  );

  assign {sel_a_s, sel_b_s, adr_s, wr_s, rd_s, din_s} = in_s;

  always_comb begin
    sel_ok   = sel_a_s & sel_b_s;
    addr_en  = sel_ok & adr_s;
    wr_ok    = sel_ok & wr_s;
    pclr_hit = wr_ok && (addr_q == ADDR_PCLR);
    addr_d   = addr_q;
    if (addr_en) addr_d = din_s;
    pclr_d   = pclr_hit;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q <= '1;
      pclr_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      pclr_q <= pclr_d;
    end
  end

  assign tk_we_o     = wr_ok && (addr_q < ADDR_W'(REG_CNT));
  assign tk_idx_o    = addr_q;
  assign tk_wdata_o  = wr_mask(addr_q, din_s);
  assign presc_clr_o = pclr_hit & ~pclr_q;

  nib_regfile #(.CNT(REG_CNT)) i_regfile (
    .clk(clk), .rst_n(rst_n_s), .we_i(tk_we_o), .idx_i(addr_q),
    .wdata_i(tk_wdata_o), .q_flat_o(regs_flat)
  );

  nib_rdmux #(.CNT(REG_CNT)) i_rdmux (
    .en_i(sel_ok & rd_s), .addr_i(addr_q), .q_flat_i(regs_flat), .dout_o(dout_o)
  );
endmodule

// File: rtl/nib_rtc_chk.sv
module nib_rtc_chk
  import nib_rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sel_ok,
  input logic [ADDR_W-1:0] addr_q,
  input logic              tk_we,
  input logic [ADDR_W-1:0] tk_idx,
  input logic [NIB_W-1:0]  tk_wdata,
  input logic              presc_clr
);
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |=> !presc_clr); // R9
  AST_CLR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |-> !tk_we); // R9
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tk_we |-> (tk_idx < ADDR_W'(REG_CNT))); // R10
  AST_NARROW_3BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tk_we && (tk_idx == IDX_SEC_T || tk_idx == IDX_MIN_T || tk_idx == IDX_WDAY))
      |-> !tk_wdata[3]); // R5
  AST_NARROW_1BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tk_we && tk_idx == IDX_MON_T) |-> (tk_wdata[3:1] == 3'b000)); // R6
  AST_H24_NO_PM: assert property (@(posedge clk) disable iff (!rst_n)
    (tk_we && tk_idx == IDX_HOUR_T && tk_wdata[HOUR_24H_BIT])
      |-> !tk_wdata[HOUR_PM_BIT]); // R7
  AST_DESEL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> $stable(addr_q)); // R2
  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> (!tk_we && !presc_clr)); // R2
endmodule

bind nib_rtc_port nib_rtc_chk i_chk (
  .clk(clk), .rst_n(rst_n_s), .sel_ok(sel_ok), .addr_q(addr_q),
  .tk_we(tk_we_o), .tk_idx(tk_idx_o), .tk_wdata(tk_wdata_o),
  .presc_clr(presc_clr_o)
);

// File: tb/test_nib_rtc_port.sv
`timescale 1ns/1ps
module test_nib_rtc_port;
  logic clk = 1'b0;
  logic rst_n, sel_a, sel_b, adr, wr, rd;
  logic [3:0] din, dout, tk_idx, tk_wdata;
  logic tk_we, pclr;
  int checks = 0, fails = 0, clr_cnt = 0, we_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nib_rtc_port i_nib_rtc_port (
    .clk(clk), .rst_n(rst_n), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .addr_stb_i(adr), .wr_stb_i(wr), .rd_stb_i(rd), .din_i(din),
    .dout_o(dout), .tk_we_o(tk_we), .tk_idx_o(tk_idx),
    .tk_wdata_o(tk_wdata), .presc_clr_o(pclr)
  );

  // {address, written nibble, expected read-back}
  localparam logic [11:0] VEC [15] = '{
    12'h099, 12'h1F7, 12'h255, 12'h3E6, 12'h433, 12'h522, 12'h5C8, 12'h566,
    12'h6F7, 12'h788, 12'h833, 12'h9CC, 12'hAF1, 12'hB77, 12'hCAA
  };

  always @(negedge clk) begin
    if (pclr === 1'b1)  clr_cnt++;
    if (tk_we === 1'b1) we_cnt++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_addr(input logic [3:0] a);
    din = a; adr = 1'b1; step(4); adr = 1'b0; step(3);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [3:0] d);
    set_addr(a); din = d; wr = 1'b1; step(4); wr = 1'b0; step(3);
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [3:0] d);
    set_addr(a); rd = 1'b1; step(4); d = dout; rd = 1'b0; step(3);
  endtask

  function automatic string tag_of(input logic [3:0] a);
    if (a == 4'd1 || a == 4'd3 || a == 4'd6) return "R5 narrow field";
    if (a == 4'd10) return "R6 month tens";
    if (a == 4'd5)  return "R7 hour tens";
    return "R4 full nibble";
  endfunction

  initial begin
    logic [3:0] v;
    int c0;
    rst_n = 1'b0; sel_a = 0; sel_b = 0; adr = 0; wr = 0; rd = 0; din = 0;
    step(3);
    chk("R1 idle output in reset", dout, 4'hF);
    rst_n = 1'b1; step(4);
    chk("R1 idle output after reset", dout, 4'hF);
    sel_a = 1; sel_b = 1; step(3);
    rd = 1'b1; step(4);
    chk("R1 latch resets to 15, reads 0", dout, 4'h0);
    rd = 1'b0; step(3);
    chk("R8 read strobe low gives F", dout, 4'hF);

    for (int k = 0; k < 15; k++) begin
      wr_reg(VEC[k][11:8], VEC[k][7:4]);
      rd_reg(VEC[k][11:8], v);
      chk(tag_of(VEC[k][11:8]), v, VEC[k][3:0]);
    end

    // R3: address follows the level; read of register 2 after load
    rd_reg(4'd2, v);
    chk("R3 address latch loads level", v, 4'h5);
    // R8: special addresses read zero
    rd_reg(4'd13, v); chk("R8 addr 13 reads 0", v, 4'h0);
    rd_reg(4'd14, v); chk("R8 addr 14 reads 0", v, 4'h0);

    // R12: two-edge latency
    set_addr(4'd0);
    rd = 1'b1; step(1);
    chk("R12 output unchanged after one edge", dout, 4'hF);
    step(1);
    chk("R12 output valid after two edges", dout, 4'h9);
    rd = 1'b0; step(3);

    // R2: deselected write, address load and read have no effect
    sel_b = 0; step(3);
    wr_reg(4'd0, 4'h4);
    set_addr(4'd2);
    rd = 1'b1; step(4);
    chk("R2 deselected read gives F", dout, 4'hF);
    rd = 1'b0; step(3);
    sel_b = 1; step(3);
    rd = 1'b1; step(4);
    chk("R2 deselected store and load ignored", dout, 4'h9);
    rd = 1'b0; step(3);

    // R11: register-file port during an accepted write
    set_addr(4'd9); din = 4'h6; wr = 1'b1; step(2);
    chk("R11 write enable high", {3'b0, tk_we}, 4'h1);
    chk("R11 index", tk_idx, 4'd9);
    chk("R11 data", tk_wdata, 4'h6);
    wr = 1'b0; step(3);
    chk("R11 write enable drops", {3'b0, tk_we}, 4'h0);
    set_addr(4'd10); din = 4'hF; wr = 1'b1; step(2);
    chk("R11 R6 masked port data", tk_wdata, 4'h1);
    wr = 1'b0; step(3);

    // R9: reset address gives one pulse, no store
    c0 = clr_cnt; we_cnt = 0;
    wr_reg(4'd13, 4'hF);
    chk("R9 one prescaler clear cycle", 4'(clr_cnt - c0), 4'd1);
    chk("R9 no register-file write", 4'(we_cnt), 4'd0);
    rd_reg(4'd0, v); chk("R9 registers unchanged", v, 4'h9);

    // R10: reference addresses ignore writes
    c0 = clr_cnt; we_cnt = 0;
    wr_reg(4'd14, 4'h3);
    wr_reg(4'd15, 4'h5);
    chk("R10 no register-file write", 4'(we_cnt), 4'd0);
    chk("R10 no clear pulse", 4'(clr_cnt - c0), 4'd0);
    rd_reg(4'd15, v); chk("R10 ref address still reads 0", v, 4'h0);
    rd_reg(4'd12, v); chk("R10 registers unchanged", v, 4'hA);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule